// File: doc/BRIEF.md
# Masked Interrupt Aggregator with DMA Halt

This block concentrates a bank of peripheral interrupt lines into one level-sensitive request for a host processor. The lower lines come from ordinary devices and are passed through at their live level. The upper lines report DMA events. The block captures each of these on a rising edge and holds it until software clears it. A per-line enable register decides which lines may drive the host request.

Each DMA line has one of two kinds, set by a constant bitmask. An informational event only latches. An error event also raises a halt output for its DMA channel. The halt stays up until software clears that status bit. Software reaches the status and enable registers through a one-cycle register port with a single address bit. Status bits are cleared by writing a zero to them.

Top module: `irqConcentrator`

## Requirements
- R1: After reset the enable register reads all zeros, every latched DMA status bit is zero, `hostIrq` is low and `dmaHalt` is all zeros.
- R2: A write with `regSel`=1 loads the full enable register, and a read with `regSel`=1 returns it unchanged.
- R3: Status bits below index `DMA_BASE` (default 16) show the live level of `srcIn`. Writes to the status register have no effect on them.
- R4: A DMA status bit (index `DMA_BASE` and up) is set on a rising edge of its `srcIn` bit and then stays set, even after the source falls. A source held high after a clear does not set the bit again.
- R5: A status write (`regSel`=0) clears each DMA status bit whose data bit is 0. Bits written as 1 keep their value.
- R6: When a rising edge on a DMA source arrives in the same cycle as a clear write to its bit, the bit ends up set.
- R7: An informational DMA line that fires again after being cleared sets its status bit again.
- R8: `hostIrq` is high exactly when some status bit is 1 and its enable bit is 1. It responds to the lower lines in the same cycle.
- R9: `dmaHalt[k]` equals status bit `DMA_BASE+k` when bit `DMA_BASE+k` of `INFO_MASK` is 0 (error kind). It is 0 for informational lines. The enable register has no effect on it. The default `INFO_MASK` is 32'h5555_0000, so even DMA lines are informational.
- R10: A read with `regSel`=0 returns the status word. Read data appears on `regRdata` after the clock edge that samples `regRd`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_LINES | Raw interrupt sources: device levels below DMA_BASE, DMA events above |
| regSel | input | 1 | Register address: 0 status, 1 enable |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | NUM_LINES | Write data |
| regRdata | output | NUM_LINES | Registered read data |
| hostIrq | output | 1 | Level request to the host |
| dmaHalt | output | NUM_LINES-DMA_BASE | Per-channel halt for error-kind DMA lines |

## Verification
The hardest case to reach from the ports is a rising edge on a DMA source that lands in the same cycle as a clear write to its own bit. The bench lowers the source first, then raises it on the same falling clock edge that presents the clear write. A read afterwards must show the bit set.

A second difficult case is a source that is still held high when its bit is cleared. The bench clears the bit without lowering the source and checks that the bit stays clear. This shows the latch responds to edges and not to levels.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic rdStatus;
    logic rdMask;
  } aggStrobes_t;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWr,
  input  logic        regRd,
  output aggStrobes_t ctl
);
  always_comb begin
    ctl.wrStatus = regWr & ~regSel;
    ctl.wrMask   = regWr &  regSel;
    ctl.rdStatus = regRd & ~regSel;
    ctl.rdMask   = regRd &  regSel;
  end

  // R2 / R10: one access names exactly one register
  assert_one_write_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrStatus, ctl.wrMask}));
  assert_one_read_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.rdStatus, ctl.rdMask}));
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DMA_BASE = 16,
  parameter logic [NUM_LINES-1:0] INFO_MASK = 32'h5555_0000
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  aggStrobes_t                     ctl,
  input  logic [NUM_LINES-1:0]            srcIn,
  input  logic [NUM_LINES-1:0]            regWdata,
  output logic [NUM_LINES-1:0]            regRdata,
  output logic                            hostIrq,
  output logic [NUM_LINES-DMA_BASE-1:0]   dmaHalt
);
  localparam int DMA_LINES = NUM_LINES - DMA_BASE;

  logic [DMA_LINES-1:0] srcPrev, dmaStat, riseSeen, clrHit;
  logic [NUM_LINES-1:0] maskReg, statusView;

  assign riseSeen   = srcIn[NUM_LINES-1:DMA_BASE] & ~srcPrev;
  assign clrHit     = {DMA_LINES{ctl.wrStatus}} & ~regWdata[NUM_LINES-1:DMA_BASE];
  assign statusView = {dmaStat, srcIn[DMA_BASE-1:0]};
  assign hostIrq    = |(statusView & maskReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev  <= '0;
      dmaStat  <= '0;
      maskReg  <= '0;
      regRdata <= '0;
    end else begin
      srcPrev <= srcIn[NUM_LINES-1:DMA_BASE];
      dmaStat <= riseSeen | (dmaStat & ~clrHit);
      if (ctl.wrMask) maskReg <= regWdata;
      if (ctl.rdStatus)    regRdata <= statusView;
      else if (ctl.rdMask) regRdata <= maskReg;
    end
  end

  for (genvar k = 0; k < DMA_LINES; k++) begin : gDma
    if (INFO_MASK[DMA_BASE+k]) begin : gInfo
      assign dmaHalt[k] = 1'b0;
    end else begin : gErr
      assign dmaHalt[k] = dmaStat[k];
      // R9: a halt is only released by a clear write to its bit
      assert_halt_release_R9: assert property (@(posedge clk) disable iff (!rstN)
        $fell(dmaHalt[k]) |-> $past(ctl.wrStatus && !regWdata[DMA_BASE+k]));
    end

    // R4: a rising source edge is captured
    assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(srcIn[DMA_BASE+k]) |=> dmaStat[k]);
    // R5: a zero written without a new edge clears the bit
    assert_zero_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.wrStatus && !regWdata[DMA_BASE+k] && !$rose(srcIn[DMA_BASE+k])) |=> !dmaStat[k]);
    // R4: with no clear and no edge the bit holds
    assert_bit_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!(ctl.wrStatus && !regWdata[DMA_BASE+k]) && !$rose(srcIn[DMA_BASE+k])) |=> $stable(dmaStat[k]));
  end

  // R1: reset leaves every line disabled
  assert_reset_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (maskReg == '0 && !hostIrq));
  // R8: with nothing enabled there is no host request
  assert_no_irq_unmasked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !hostIrq);
endmodule

// File: rtl/irqConcentrator.sv
module irqConcentrator
  import irqAggPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DMA_BASE = 16,
  parameter logic [NUM_LINES-1:0] INFO_MASK = 32'h5555_0000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LINES-1:0]          srcIn,
  input  logic                          regSel,
  input  logic                          regWr,
  input  logic                          regRd,
  input  logic [NUM_LINES-1:0]          regWdata,
  output logic [NUM_LINES-1:0]          regRdata,
  output logic                          hostIrq,
  output logic [NUM_LINES-DMA_BASE-1:0] dmaHalt
);
  aggStrobes_t ctl;

  irqAggCtrl uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd), .ctl(ctl)
  );

  irqAggDatapath #(
    .NUM_LINES(NUM_LINES), .DMA_BASE(DMA_BASE), .INFO_MASK(INFO_MASK)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcIn(srcIn), .regWdata(regWdata),
    .regRdata(regRdata), .hostIrq(hostIrq), .dmaHalt(dmaHalt)
  );
endmodule

// File: tb/tb_irqConcentrator.sv
module tb_irqConcentrator;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int DB = 16;
  localparam logic [31:0] INFO = 32'h5555_0000;

  logic clk = 0, rstN = 0;
  logic [NL-1:0] srcIn = '0, regWdata = '0, regRdata;
  logic regSel = 0, regWr = 0, regRd = 0, hostIrq;
  logic [NL-DB-1:0] dmaHalt;
  int checks = 0, errors = 0;

  irqConcentrator dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic sel, logic [31:0] d);
    regSel = sel; regWr = 1; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic doRead(logic sel, output logic [31:0] d);
    regSel = sel; regRd = 1;
    @(negedge clk); regRd = 0; d = regRdata;
  endtask

  task automatic pulse(int idx);
    srcIn[idx] = 1; @(negedge clk);
    srcIn[idx] = 0; @(negedge clk);
  endtask

  function automatic logic [15:0] expHalt(logic [31:0] stat);
    return stat[31:16] & ~INFO[31:16];
  endfunction

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk); @(negedge clk); rstN = 1; @(negedge clk);
    // R1 reset state
    chk("R1 hostIrq", {31'b0, hostIrq}, 0);
    chk("R1 dmaHalt", {16'b0, dmaHalt}, 0);
    doRead(1, rd); chk("R1 mask", rd, 0);
    doRead(0, rd); chk("R1 status", rd, 0);
    // R2 mask readback
    doWrite(1, 32'hA5A5_3C3C); doRead(1, rd); chk("R2 mask readback", rd, 32'hA5A5_3C3C);
    doWrite(1, 0);
    // R3 / R8 sweep of device lines
    for (int i = 0; i < DB; i++) begin
      srcIn = 32'b1 << i; @(negedge clk);
      doRead(0, rd); chk("R3/R10 live level", rd, 32'b1 << i);
      doWrite(0, 32'h0); doRead(0, rd); chk("R3 write ignored", rd, 32'b1 << i);
      chk("R8 disabled no irq", {31'b0, hostIrq}, 0);
      doWrite(1, 32'b1 << i); #1 chk("R8 enabled irq", {31'b0, hostIrq}, 1);
      doWrite(1, ~(32'b1 << i)); #1 chk("R8 other lines enabled", {31'b0, hostIrq}, 0);
      srcIn = 0; doWrite(1, 0);
      doRead(0, rd); chk("R3 follows low", rd, 0);
    end
    // R4 / R9 / R5 sweep of DMA lines
    for (int j = DB; j < NL; j++) begin
      pulse(j);
      doRead(0, rd); chk("R4 latched", rd, 32'b1 << j);
      chk("R9 halt kind", {16'b0, dmaHalt}, {16'b0, expHalt(32'b1 << j)});
      chk("R8 halt w/o mask irq", {31'b0, hostIrq}, 0);
      doWrite(1, 32'b1 << j); #1 chk("R8 dma irq", {31'b0, hostIrq}, 1);
      chk("R9 mask no effect", {16'b0, dmaHalt}, {16'b0, expHalt(32'b1 << j)});
      doWrite(0, ~(32'b1 << j)); doRead(0, rd); chk("R5 cleared", rd, 0);
      chk("R9 halt released", {16'b0, dmaHalt}, 0);
      doWrite(1, 0);
    end
    // R5 selective clear
    pulse(16); pulse(17); pulse(18);
    doWrite(0, ~(32'b1 << 17)); doRead(0, rd);
    chk("R5 ones keep", rd, 32'h0005_0000);
    chk("R9 mixed halt", {16'b0, dmaHalt}, 0);
    doWrite(0, 0); doRead(0, rd); chk("R5 clear all", rd, 0);
    // R6 edge during clear
    pulse(21);
    srcIn[21] = 1; regSel = 0; regWr = 1; regWdata = ~(32'b1 << 21);
    @(negedge clk); regWr = 0;
    doRead(0, rd); chk("R6 edge wins", rd, 32'b1 << 21);
    chk("R6 halt kept", {16'b0, dmaHalt}, 16'b1 << 5);
    // R4 level held after clear does not relatch
    doWrite(0, 0); @(negedge clk); doRead(0, rd); chk("R4 no relatch on level", rd, 0);
    srcIn[21] = 0; @(negedge clk);
    // R7 informational refire
    pulse(16); doWrite(0, 0); doRead(0, rd); chk("R7 cleared", rd, 0);
    pulse(16); doRead(0, rd); chk("R7 refire sets", rd, 32'b1 << 16);
    chk("R7 info no halt", {16'b0, dmaHalt}, 0);
    // R10 read data holds between reads
    @(negedge clk); @(negedge clk); chk("R10 rdata held", regRdata, 32'b1 << 16);
    finishRun();
  end
endmodule